// File: doc/BRIEF.md
# Lockable Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations in a fully associative array of up to 64 entries. Each entry carries a virtual page number, a page-size code, a context number, a partition number, a flag that marks a real (non-virtual) translation, a physical page number, three permission bits, and lock, valid and used state. The entry count is the parameter `N`; a data-side instance keeps the default of 64, and an instruction-side instance sets it to 48.

One request is presented per cycle on `req_*`, qualified by `req_valid`, and selected by the 3-bit `req_op` code. The codes are: 0 lookup, 1 insert, 2 remove page, 3 remove context, 4 remove partition, 5 flush, 6 read tag word, 7 read data word. Lookup results and read words are combinational on the current contents. State changes (insert, removal, flush, used-bit updates) take effect at the next rising clock edge. A page of size code `s` spans 2^(13+3s) bytes, so the codes 0 to 3 give 8 KiB, 64 KiB, 512 KiB and 4 MiB.

The block does no table walk, fault reporting or privilege checking. The permission bits of the hit entry travel out with the translation. Entries are filled by an agent outside the block.

Top module: `tlb_core`

## Requirements
- R1: After reset every entry is invalid. Tag reads (op 6) and data reads (op 7) of every index return all ones, and lookups (op 0) report no hit.
- R2: A lookup hits an entry that is valid and has an equal partition and an equal real flag. The entry's context must also equal the request context, where a real request counts as context 0. The request page must lie inside the entry's page range. When several entries match, `hit_idx` is the lowest matching index.
- R3: On a hit, `hit_pa` takes bits 12:0 from the request address. Above bit 12 it takes the entry's physical page with its low 3·size bits replaced by the matching bits of the request's virtual page. `hit_perm` is the entry's permission field.
- R4: Before an insert (op 1) writes, every valid entry with the same partition, real flag, effective context and size code, and the same page under that size, is invalidated.
- R5: An insert with `req_fixed` low writes the lowest-indexed invalid entry (after the R4 step). If no entry is invalid, it scans forward from the last round-robin victim, wrapping at N, and takes the first unlocked entry; that entry becomes the new round-robin position. If every entry is locked, it writes entry N-1 and leaves the position unchanged. The position is N-1 after reset.
- R6: An insert with `req_fixed` high writes entry `req_index` whatever that entry's state. A real insert stores context 0.
- R7: An insert and a lookup hit both set the used bit of the touched entry. If all N used bits are then set, the used bits of all unlocked entries are cleared, except the touched entry's. A used bit is never set on an invalid entry.
- R8: Remove page (op 2) invalidates every entry that a lookup with the same request fields would match.
- R9: Remove context (op 3) invalidates every entry whose partition and stored context equal the request's, locked entries included.
- R10: Remove partition (op 4) invalidates every unlocked entry of the request partition and leaves locked entries valid.
- R11: Flush (op 5) clears every valid and used bit in one cycle.
- R12: A tag read of a valid entry returns the partition in bits 63:61, the real flag in bit 60, the inverted size code in bits 57:56, the virtual page in bits 47:13 and the context in bits 12:0, with all other bits zero.
- R13: A data read of a valid entry returns lock in bit 63, used in bit 62, permission in bits 61:59, the size code in bits 57:56 and the physical page in bits 39:13, with all other bits zero. Outside a read of a valid index, `rd_data` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7, see above) |
| req_va | input | 48 | Virtual address |
| req_ctx | input | 13 | Context number |
| req_part | input | 3 | Partition number |
| req_real | input | 1 | Real translation flag |
| req_size | input | 2 | Page size code for insert |
| req_ppn | input | 27 | Physical page number for insert |
| req_perm | input | 3 | Permission bits for insert |
| req_lock | input | 1 | Lock bit for insert |
| req_fixed | input | 1 | Insert to `req_index` instead of the replacement choice |
| req_index | input | $clog2(N) | Entry index for fixed insert and reads |
| hit | output | 1 | Lookup found a matching entry |
| hit_idx | output | $clog2(N) | Index of the lowest matching entry |
| hit_pa | output | 40 | Translated physical address |
| hit_perm | output | 3 | Permission bits of the hit entry |
| rd_data | output | 64 | Tag or data word of `req_index` |

## Verification
The in-module properties check on every cycle that a reported hit points at a valid entry. They also check that used bits stay inside the valid set, that a fixed insert leaves its index valid, that a flush empties the array, and that a partition removal keeps every locked valid entry. Which entry a replacement picks, the round-robin walk past locked entries, the used-bit epoch reset, lowest-index priority among overlapping pages, and the exact address composition can only be shown by the bench. The bench compares every cycle against its own behavioural model, using directed sequences and a random mix of operations.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W = 48;          // virtual address width, at most 56
    parameter int PA_W = 40;          // physical address width, at most 56
    localparam int OFS_W  = 13;       // offset bits of the smallest page
    localparam int CTX_W  = 13;
    localparam int PART_W = 3;
    localparam int SZ_W   = 2;
    localparam int PERM_W = 3;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = PA_W - OFS_W;
    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_INSERT    = 3'd1,
        OP_DROP_PAGE = 3'd2,
        OP_DROP_CTX  = 3'd3,
        OP_DROP_PART = 3'd4,
        OP_FLUSH     = 3'd5,
        OP_RD_TAG    = 3'd6,
        OP_RD_DATA   = 3'd7
    } op_e;

    typedef struct packed {
        logic              vld;
        logic              used;
        logic              lock;
        logic              rflag;
        logic [PART_W-1:0] part;
        logic [CTX_W-1:0]  ctx;
        logic [SZ_W-1:0]   sz;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;

    // page-number bits that take part in a compare for a given size code
    function automatic logic [VPN_W-1:0] vpn_keep(input logic [SZ_W-1:0] sz);
        return ~((VPN_W'(1) << (3 * sz)) - VPN_W'(1));
    endfunction

    function automatic logic [PPN_W-1:0] ppn_keep(input logic [SZ_W-1:0] sz);
        return ~((PPN_W'(1) << (3 * sz)) - PPN_W'(1));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 64
) (
    input  tlb_ent_t [N-1:0]    ent,
    input  logic [VPN_W-1:0]    vpn,
    input  logic [CTX_W-1:0]    ctx_eff,
    input  logic [CTX_W-1:0]    ctx_raw,
    input  logic [PART_W-1:0]   part,
    input  logic                rflag,
    input  logic [SZ_W-1:0]     sz,
    output logic [N-1:0]        in_range,
    output logic [N-1:0]        same_page,
    output logic [N-1:0]        ctx_hit
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic key_ok;
        assign key_ok = ent[g].vld && (ent[g].part == part) &&
                        (ent[g].rflag == rflag) && (ent[g].ctx == ctx_eff);
        assign in_range[g]  = key_ok &&
            (((ent[g].vpn ^ vpn) & vpn_keep(ent[g].sz)) == '0);
        assign same_page[g] = key_ok && (ent[g].sz == sz) &&
            (((ent[g].vpn ^ vpn) & vpn_keep(sz)) == '0);
        assign ctx_hit[g]   = (ent[g].part == part) && (ent[g].ctx == ctx_raw);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  avail,
    input  logic [N-1:0]  locked,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] pick,
    output logic          rotate
);
    logic found;
    int   cand;

    always_comb begin
        pick   = IW'(N - 1);
        rotate = 1'b0;
        found  = 1'b0;
        cand   = 0;
        for (int i = 0; i < N; i++) begin
            if (!found && avail[i]) begin
                pick  = IW'(i);
                found = 1'b1;
            end
        end
        for (int k = 1; k <= N; k++) begin
            cand = int'(last) + k;
            if (cand >= N) cand = cand - N;
            if (!found && !locked[cand]) begin
                pick   = IW'(cand);
                rotate = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlb_pkg::*;
#(
    parameter int N = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic [2:0]                          req_op,
    input  logic [VA_W-1:0]                     req_va,
    input  logic [CTX_W-1:0]                    req_ctx,
    input  logic [PART_W-1:0]                   req_part,
    input  logic                                req_real,
    input  logic [SZ_W-1:0]                     req_size,
    input  logic [PPN_W-1:0]                    req_ppn,
    input  logic [PERM_W-1:0]                   req_perm,
    input  logic                                req_lock,
    input  logic                                req_fixed,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] req_index,
    output logic                                hit,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] hit_idx,
    output logic [PA_W-1:0]                     hit_pa,
    output logic [PERM_W-1:0]                   hit_perm,
    output logic [WORD_W-1:0]                   rd_data
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        tlb_ent_t [N-1:0] ent;
        logic [IW-1:0]    rr;
    } st_t;

    st_t s_q, s_d;

    op_e              op;
    logic [CTX_W-1:0] ctx_eff;
    logic [N-1:0]     in_range, same_page, ctx_hit;
    logic [N-1:0]     vld_vec, used_vec, lock_vec, avail;
    logic             hit_any;
    logic [IW-1:0]    hit_sel;
    logic [IW-1:0]    vict_pick, tgt;
    logic             vict_rot, touch, idx_ok;
    int               used_cnt;
    tlb_ent_t         hent, rent;

    assign op      = op_e'(req_op);
    assign ctx_eff = req_real ? '0 : req_ctx;
    assign idx_ok  = int'(req_index) < N;

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign vld_vec[g]  = s_q.ent[g].vld;
        assign used_vec[g] = s_q.ent[g].used;
        assign lock_vec[g] = s_q.ent[g].lock;
    end
    assign avail = ~(vld_vec & ~same_page);

    tlb_match #(.N(N)) u_match (
        .ent(s_q.ent), .vpn(req_va[VA_W-1:OFS_W]), .ctx_eff(ctx_eff),
        .ctx_raw(req_ctx), .part(req_part), .rflag(req_real), .sz(req_size),
        .in_range(in_range), .same_page(same_page), .ctx_hit(ctx_hit)
    );

    tlb_victim #(.N(N), .IW(IW)) u_victim (
        .avail(avail), .locked(lock_vec), .last(s_q.rr),
        .pick(vict_pick), .rotate(vict_rot)
    );

    // lowest matching index wins
    always_comb begin
        hit_any = |in_range;
        hit_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (in_range[i]) hit_sel = IW'(i);
        end
    end

    assign hent     = s_q.ent[hit_sel];
    assign hit      = req_valid && (op == OP_LOOKUP) && hit_any;
    assign hit_idx  = hit_sel;
    assign hit_perm = hent.perm;
    assign hit_pa   = {(hent.ppn & ppn_keep(hent.sz)) |
                       (req_va[PA_W-1:OFS_W] & ~ppn_keep(hent.sz)),
                       req_va[OFS_W-1:0]};

    assign rent = s_q.ent[req_index];
    always_comb begin
        rd_data = '1;
        if (req_valid && idx_ok && rent.vld) begin
            if (op == OP_RD_TAG) begin
                rd_data = '0;
                rd_data[63:61]        = rent.part;
                rd_data[60]           = rent.rflag;
                rd_data[57:56]        = ~rent.sz;
                rd_data[VA_W-1:OFS_W] = rent.vpn;
                rd_data[CTX_W-1:0]    = rent.ctx;
            end else if (op == OP_RD_DATA) begin
                rd_data = '0;
                rd_data[63]           = rent.lock;
                rd_data[62]           = rent.used;
                rd_data[61:59]        = rent.perm;
                rd_data[57:56]        = rent.sz;
                rd_data[PA_W-1:OFS_W] = rent.ppn;
            end
        end
    end

    always_comb begin
        s_d      = s_q;
        tgt      = '0;
        touch    = 1'b0;
        used_cnt = 0;
        if (req_valid) begin
            case (op)
                OP_LOOKUP: begin
                    if (hit_any) begin
                        tgt   = hit_sel;
                        touch = 1'b1;
                    end
                end
                OP_INSERT: begin
                    if (!req_fixed || idx_ok) begin
                        for (int i = 0; i < N; i++) begin
                            if (same_page[i]) begin
                                s_d.ent[i].vld  = 1'b0;
                                s_d.ent[i].used = 1'b0;
                            end
                        end
                        tgt = req_fixed ? req_index : vict_pick;
                        if (!req_fixed && vict_rot) s_d.rr = vict_pick;
                        s_d.ent[tgt] = '{vld: 1'b1, used: 1'b1, lock: req_lock,
                                         rflag: req_real, part: req_part,
                                         ctx: ctx_eff, sz: req_size,
                                         vpn: req_va[VA_W-1:OFS_W],
                                         ppn: req_ppn, perm: req_perm};
                        touch = 1'b1;
                    end
                end
                OP_DROP_PAGE, OP_DROP_CTX, OP_DROP_PART, OP_FLUSH: begin
                    for (int i = 0; i < N; i++) begin
                        if ((op == OP_DROP_PAGE && in_range[i]) ||
                            (op == OP_DROP_CTX && ctx_hit[i]) ||
                            (op == OP_DROP_PART && !s_q.ent[i].lock &&
                             s_q.ent[i].part == req_part) ||
                            (op == OP_FLUSH)) begin
                            s_d.ent[i].vld  = 1'b0;
                            s_d.ent[i].used = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (touch) begin
            s_d.ent[tgt].used = 1'b1;
            for (int i = 0; i < N; i++) used_cnt += int'(s_d.ent[i].used);
            if (used_cnt == N) begin
                for (int i = 0; i < N; i++)
                    s_d.ent[i].used = s_d.ent[i].used & s_d.ent[i].lock;
                s_d.ent[tgt].used = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.rr <= IW'(N - 1);
        end else begin
            s_q <= s_d;
        end
    end

    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> vld_vec[hit_idx]); // R2
    AST_FIXED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_INSERT && req_fixed && idx_ok)
        |=> vld_vec[$past(req_index)]); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_FLUSH) |=> (vld_vec == '0 && used_vec == '0)); // R11
    AST_PART_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_DROP_PART)
        |=> ((vld_vec & $past(vld_vec & lock_vec)) == $past(vld_vec & lock_vec))); // R10
    AST_USED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (used_vec & ~vld_vec) == '0); // R7
endmodule

// File: tb/tlb_core_tb.sv
module tlb_core_tb;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [VA_W-1:0]   req_va = '0;
    logic [CTX_W-1:0]  req_ctx = '0;
    logic [PART_W-1:0] req_part = '0;
    logic              req_real = 1'b0;
    logic [SZ_W-1:0]   req_size = '0;
    logic [PPN_W-1:0]  req_ppn = '0;
    logic [PERM_W-1:0] req_perm = '0;
    logic              req_lock = 1'b0;
    logic              req_fixed = 1'b0;
    logic [IW-1:0]     req_index = '0;
    logic              hit;
    logic [IW-1:0]     hit_idx;
    logic [PA_W-1:0]   hit_pa;
    logic [PERM_W-1:0] hit_perm;
    logic [63:0]       rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    tlb_core #(.N(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_va(req_va), .req_ctx(req_ctx), .req_part(req_part),
        .req_real(req_real), .req_size(req_size), .req_ppn(req_ppn),
        .req_perm(req_perm), .req_lock(req_lock), .req_fixed(req_fixed),
        .req_index(req_index), .hit(hit), .hit_idx(hit_idx), .hit_pa(hit_pa),
        .hit_perm(hit_perm), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference state
    bit          m_vld [NE], m_used [NE], m_lock [NE], m_real [NE];
    int          m_part [NE], m_ctx [NE], m_sz [NE], m_perm [NE];
    logic [63:0] m_vpn [NE], m_ppn [NE];
    int          m_rr = NE - 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bool_in_page(input int i, input logic [63:0] vpn, input int sz);
        return ((m_vpn[i] ^ vpn) >> (3 * sz)) == 0;
    endfunction

    function automatic int find(input logic [63:0] vpn, input int ctx, input int part, input bit rl);
        for (int i = 0; i < NE; i++)
            if (m_vld[i] && m_part[i] == part && m_real[i] == rl && m_ctx[i] == ctx &&
                bool_in_page(i, vpn, m_sz[i])) return i;
        return -1;
    endfunction

    task automatic touch(input int t);
        int cnt = 0;
        m_used[t] = 1;
        for (int i = 0; i < NE; i++) cnt += m_used[i] ? 1 : 0;
        if (cnt == NE) begin
            for (int i = 0; i < NE; i++) if (!m_lock[i]) m_used[i] = 0;
            m_used[t] = 1;
        end
    endtask

    task automatic go(input int op, input logic [63:0] va, input int ctx, input int part,
                      input bit rl, input int sz, input logic [63:0] pa, input int perm,
                      input bit lk, input bit fx, input int ix, input string tag);
        logic [63:0] vpn, exp_rd, exp_pa, keep, p;
        int ectx, f, t, s;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_va = va[VA_W-1:0];
        req_ctx = CTX_W'(ctx); req_part = PART_W'(part); req_real = rl;
        req_size = SZ_W'(sz); req_ppn = pa[PA_W-1:OFS_W]; req_perm = PERM_W'(perm);
        req_lock = lk; req_fixed = fx; req_index = IW'(ix);
        #(CLK_PERIOD / 4);
        vpn  = {16'd0, va[VA_W-1:OFS_W]};
        ectx = rl ? 0 : ctx;
        f    = find(vpn, ectx, part, rl);
        chk(hit == (op == 0 && f >= 0), tag, "hit", 64'(hit), 64'(op == 0 && f >= 0));
        if (op == 0 && f >= 0) begin
            s = 3 * m_sz[f];
            keep = ~((64'd1 << s) - 1);
            p = ((m_ppn[f] & keep) | (vpn & ~keep)) & ((64'd1 << PPN_W) - 1);
            exp_pa = (p << OFS_W) | (va & 64'h1fff);
            chk(int'(hit_idx) == f, tag, "hit_idx", 64'(hit_idx), 64'(f));
            chk(64'(hit_pa) == exp_pa, tag, "hit_pa", 64'(hit_pa), exp_pa);
            chk(int'(hit_perm) == m_perm[f], tag, "hit_perm", 64'(hit_perm), 64'(m_perm[f]));
        end
        exp_rd = '1;
        if (op == 6 && m_vld[ix])
            exp_rd = (64'(m_part[ix]) << 61) | (64'(m_real[ix]) << 60) |
                     (64'((~m_sz[ix]) & 3) << 56) | (m_vpn[ix] << 13) | 64'(m_ctx[ix]);
        if (op == 7 && m_vld[ix])
            exp_rd = (64'(m_lock[ix]) << 63) | (64'(m_used[ix]) << 62) |
                     (64'(m_perm[ix]) << 59) | (64'(m_sz[ix]) << 56) | (m_ppn[ix] << 13);
        chk(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
        // reference state update for the coming edge
        case (op)
            0: if (f >= 0) touch(f);
            1: begin
                for (int i = 0; i < NE; i++)
                    if (m_vld[i] && m_part[i] == part && m_real[i] == rl && m_ctx[i] == ectx &&
                        m_sz[i] == sz && bool_in_page(i, vpn, sz)) begin
                        m_vld[i] = 0; m_used[i] = 0;
                    end
                t = -1;
                if (fx) t = ix;
                else begin
                    for (int i = 0; i < NE; i++) if (t < 0 && !m_vld[i]) t = i;
                    for (int k = 1; k <= NE; k++)
                        if (t < 0 && !m_lock[(m_rr + k) % NE]) begin
                            t = (m_rr + k) % NE; m_rr = t;
                        end
                    if (t < 0) t = NE - 1;
                end
                m_vld[t] = 1; m_lock[t] = lk; m_real[t] = rl; m_part[t] = part;
                m_ctx[t] = ectx; m_sz[t] = sz; m_vpn[t] = vpn; m_perm[t] = perm;
                m_ppn[t] = pa >> OFS_W & ((64'd1 << PPN_W) - 1);
                touch(t);
            end
            default:
                for (int i = 0; i < NE; i++)
                    if ((op == 2 && m_vld[i] && m_part[i] == part && m_real[i] == rl &&
                         m_ctx[i] == ectx && bool_in_page(i, vpn, m_sz[i])) ||
                        (op == 3 && m_part[i] == part && m_ctx[i] == ctx) ||
                        (op == 4 && !m_lock[i] && m_part[i] == part) || op == 5) begin
                        m_vld[i] = 0; m_used[i] = 0;
                    end
        endcase
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        for (int i = 0; i < NE; i++) go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R1 tag");
        for (int i = 0; i < NE; i++) go(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R1 data");
        go(0, 64'h2000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 lookup");
        // R5 free-first fill, four page sizes
        for (int s = 0; s < 4; s++)
            go(1, 64'h0100_0000 * (s + 1), 5, 1, 0, s, 64'h12_3400_0000 + 64'h10_0000 * s,
               s, 0, 0, 0, "R5 free fill");
        // R3 translation within each page size
        for (int s = 0; s < 4; s++)
            go(0, 64'h0100_0000 * (s + 1) + 64'h1234 * (s + 1), 5, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        go(0, 64'h0100_0000, 6, 1, 0, 0, 0, 0, 0, 0, 0, "R2 ctx miss");
        go(0, 64'h0100_0000, 5, 2, 0, 0, 0, 0, 0, 0, 0, "R2 part miss");
        // R2 real translations use context 0
        go(1, 64'h0700_0000, 7, 1, 1, 0, 64'h55_0000_0000, 2, 0, 0, 0, "R6 real ctx");
        go(0, 64'h0700_0010, 3, 1, 1, 0, 0, 0, 0, 0, 0, "R2 real");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4, "R12 real tag");
        // R7 filling the array triggers the used epoch
        for (int k = 0; k < 3; k++)
            go(1, 64'h0900_0000 + 64'h2000 * k, 2, 0, 0, 0, 64'h2000 * k, 1, 0, 0, 0, "R7 fill");
        for (int i = 0; i < NE; i++) go(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R7 R13 data");
        for (int i = 0; i < NE; i++) go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R12 tag");
        // R6 locked fixed inserts, then R5 round-robin past them
        go(1, 64'h0a00_0000, 11, 3, 0, 0, 64'h1_0000_0000, 4, 1, 1, 0, "R6 fixed 0");
        go(1, 64'h0b00_0000, 12, 3, 0, 1, 64'h2_0000_0000, 5, 1, 1, 1, "R6 fixed 1");
        for (int k = 0; k < 3; k++)
            go(1, 64'h0c00_0000 + 64'h2000 * k, 4, 0, 0, 0, 64'h3000_0000, 6, 0, 0, 0, "R5 rr");
        for (int i = 0; i < NE; i++) go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R5 rr tag");
        // R4 conflicting insert replaces the old copy
        go(1, 64'h0c00_4000, 4, 0, 0, 0, 64'h7000_0000, 7, 0, 0, 0, "R4 conflict");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4, "R4 tag");
        go(0, 64'h0c00_4100, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R4 lookup");
        // R2 overlapping pages of different sizes, lowest index wins
        go(1, 64'h0d00_0000, 9, 2, 0, 0, 64'h4000_0000, 1, 0, 1, 6, "R2 overlap a");
        go(1, 64'h0d00_0000, 9, 2, 0, 1, 64'h5000_0000, 2, 0, 1, 3, "R2 overlap b");
        go(0, 64'h0d00_0040, 9, 2, 0, 0, 0, 0, 0, 0, 0, "R2 lowest");
        // R8 remove page clears both overlapping entries
        go(2, 64'h0d00_0000, 9, 2, 0, 0, 0, 0, 0, 0, 0, "R8 drop page");
        go(0, 64'h0d00_0040, 9, 2, 0, 0, 0, 0, 0, 0, 0, "R8 lookup");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R8 tag");
        // R9 remove context takes a locked entry too
        go(3, 0, 11, 3, 0, 0, 0, 0, 0, 0, 0, "R9 drop ctx");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 tag");
        // R10 remove partition spares the locked one
        go(1, 64'h0e00_0000, 13, 3, 0, 0, 64'h6000_0000, 0, 0, 1, 5, "R10 setup");
        go(4, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, "R10 drop part");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 locked kept");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, "R10 unlocked gone");
        // R5 everything locked: entry N-1 is overwritten
        for (int i = 0; i < NE; i++)
            go(1, 64'h1000_0000 + 64'h2000 * i, 1, 1, 0, 0, 64'h2000 * i, 0, 1, 1, i, "R5 lock all");
        go(1, 64'h2000_0000, 1, 1, 0, 0, 64'h8000_0000, 3, 0, 0, 0, "R5 all locked");
        go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, NE - 1, "R5 last entry");
        go(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, NE - 1, "R13 last data");
        // R11 flush
        go(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 flush");
        for (int i = 0; i < NE; i++) go(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, "R11 tag");
        // random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [63:0] va;
            va = (64'($urandom_range(0, 15)) << 13) | 64'($urandom_range(0, 8191));
            if ($urandom_range(0, 3) == 0) va = va | (64'($urandom_range(1, 3)) << 30);
            go($urandom_range(0, 7), va, $urandom_range(0, 2), $urandom_range(0, 1),
               1'($urandom_range(0, 1)), $urandom_range(0, 3),
               64'($urandom_range(0, 32'h7fff_ffff)) << 8, $urandom_range(0, 7),
               $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
               $urandom_range(0, NE - 1), "R2 R7 random");
        end
        @(negedge clk);
        req_valid = 1'b0;
        finish_run();
    end
endmodule